// File: doc/BRIEF.md
# Byte-to-Word Packing DMA Channel

This block is a single DMA channel that moves a block of bytes from an 8-bit source into a 16-bit destination. For every destination word it performs two byte reads and then one word write, placing the first byte in the upper half of the word and the second byte in the lower half. A source pointer, a destination pointer and a byte counter are loaded when a start command arrives while the channel is idle. The source pointer can be set to step by two per byte, which keeps every read on the same byte lane of a 16-bit bus.

Each bus cycle stays open until the responder acknowledges it or signals a bus error. The channel stops when the byte counter is exhausted, when an external termination input is seen, or when a bus error occurs. A four-bit status field records the cause of each stop, and each bit is cleared by writing one to it. During the final write of a block that ends on count, the channel drives its own termination output.

Top module: `pack_dma`

## Requirements
- R1: Each word transfer is two byte reads (`bus_we`=0) followed by one word write (`bus_we`=1) to the destination pointer, and the written word carries the first byte in bits 15:8 and the second byte in bits 7:0.
- R2: The source pointer starts at `src_base` and advances by 1 after each byte read, or by 2 when `src_step2` was high at start.
- R3: The byte counter drops by one per byte read. The destination pointer starts at `dst_base` and advances by 2 per word write. With an odd count, the last word is written after a single read, with bits 7:0 equal to zero.
- R4: When the count runs out, the channel finishes after the last word write, sets status bit 0 and drops `busy`. `done_out` is high during that final write cycle and at no other time.
- R5: If `done_in` is high in a cycle of the second read or of the write, the channel finishes after the current word write completes and sets status bit 0.
- R6: A bus error during a read sets status bit 1 and stops the channel at once, with no further bus cycle.
- R7: A bus error during a write sets status bit 2 and stops the channel at once.
- R8: If `done_in` is high during the first read of a pair, status bit 3 is set and the channel stops at once without writing that word.
- R9: A status write clears each bit 3:0 whose `stat_wdata` bit is 1. Bits written as 0 keep their value, and bits 7:4 always read 0.
- R10: `chan_rst` clears all status bits and returns a busy channel to idle on the next clock.
- R11: `start` has no effect while the channel is busy or when `byte_count` is zero.
- R12: A bus cycle holds `bus_req`, `bus_we` and `bus_addr` stable until `bus_ack` or `bus_err` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start command, taken only when idle |
| chan_rst | input | 1 | Channel reset: abort and clear status |
| src_step2 | input | 1 | Source steps by 2 per byte when high at start |
| src_base | input | 16 | Source start address |
| dst_base | input | 16 | Destination start address |
| byte_count | input | 16 | Number of bytes to move |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data, one clears a bit |
| status | output | 8 | Status: bit0 done, bit1 source error, bit2 destination error, bit3 unsynchronized termination |
| busy | output | 1 | Channel active |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 for word write, 0 for byte read |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Packed write word |
| bus_rdata | input | 8 | Read byte |
| bus_ack | input | 1 | Cycle acknowledge |
| bus_err | input | 1 | Cycle bus error |
| done_in | input | 1 | External termination request |
| done_out | output | 1 | Channel-driven termination during final write |

## Verification
A wrong sequencer state shows up within one bus cycle: a read appears where a write is expected, the address leaves its computed progression, or `busy` stays high one cycle past a terminating response. A pointer or counter error is visible at the next address or at the first packed word. A status fault appears on the cycle after the stop, as a wrong stop-cause bit or a bit that survives a clearing write. Every bus cycle is compared against addresses and packed data computed from the base values, step mode and count, under random wait states.

// File: rtl/pack_dma_pkg.sv
package pack_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_WR   = 2'd3
  } seq_state_t;

  localparam int unsigned STAT_W    = 8;
  localparam int unsigned EV_W      = 4;
  localparam int unsigned SB_DONE   = 0;
  localparam int unsigned SB_SRCERR = 1;
  localparam int unsigned SB_DSTERR = 2;
  localparam int unsigned SB_UNSYNC = 3;
endpackage

// File: rtl/pack_dma_ptrs.sv
module pack_dma_ptrs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] cnt_init,
  input  logic          step2,
  input  logic          src_adv,
  input  logic          dst_adv,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] cnt
);
  localparam logic [AW-1:0] INC_ONE = AW'(1);
  localparam logic [AW-1:0] INC_TWO = AW'(2);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d, src_inc;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step_q, step_d;

  assign src_inc = step_q ? INC_TWO : INC_ONE;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    step_d = step_q;
    if (load) begin
      src_d  = src_base;
      dst_d  = dst_base;
      cnt_d  = cnt_init;
      step_d = step2;
    end else begin
      if (src_adv) begin
        src_d = src_q + src_inc;
        cnt_d = cnt_q - CNT_ONE;
      end
      if (dst_adv) begin
        dst_d = dst_q + INC_TWO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      step_q <= step_d;
    end
  end

  assign src_ptr = src_q;
  assign dst_ptr = dst_q;
  assign cnt     = cnt_q;

  // R2: source advances by the step chosen at load
  assert_src_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_adv && !load) |=> (src_ptr == $past(src_ptr) + ($past(step_q) ? INC_TWO : INC_ONE)));

  // R3: destination advances by two per word
  assert_dst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_adv && !load) |=> (dst_ptr == $past(dst_ptr) + INC_TWO));

  // R3: never read a byte with the counter already empty
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    src_adv |-> (cnt != '0));
endmodule

// File: rtl/pack_dma_seq.sv
module pack_dma_seq
  import pack_dma_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            chan_rst,
  input  logic            cnt_init_nz,
  input  logic [CW-1:0]   cnt,
  input  logic            bus_ack,
  input  logic            bus_err,
  input  logic [7:0]      bus_rdata,
  input  logic            done_in,
  output logic            load,
  output logic            src_adv,
  output logic            dst_adv,
  output logic            bus_req,
  output logic            bus_we,
  output logic [15:0]     word,
  output logic [EV_W-1:0] ev,
  output logic            busy,
  output logic            done_out
);
  localparam logic [CW-1:0] CNT_LAST = CW'(1);

  seq_state_t state_q, state_d;
  logic [7:0] hi_q, hi_d, lo_q, lo_d;
  logic       ext_q, ext_d;

  always_comb begin
    state_d = state_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    ext_d   = ext_q;
    load    = 1'b0;
    src_adv = 1'b0;
    dst_adv = 1'b0;
    ev      = '0;
    if (chan_rst) begin
      state_d = ST_IDLE;
      ext_d   = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start && cnt_init_nz) begin
            load    = 1'b1;
            ext_d   = 1'b0;
            state_d = ST_RD1;
          end
        end
        ST_RD1: begin
          if (bus_err) begin
            ev[SB_SRCERR] = 1'b1;
            state_d       = ST_IDLE;
          end else if (done_in) begin
            ev[SB_UNSYNC] = 1'b1;
            state_d       = ST_IDLE;
          end else if (bus_ack) begin
            hi_d    = bus_rdata;
            lo_d    = 8'h00;
            src_adv = 1'b1;
            state_d = (cnt == CNT_LAST) ? ST_WR : ST_RD2;
          end
        end
        ST_RD2: begin
          if (bus_err) begin
            ev[SB_SRCERR] = 1'b1;
            state_d       = ST_IDLE;
          end else begin
            if (done_in) ext_d = 1'b1;
            if (bus_ack) begin
              lo_d    = bus_rdata;
              src_adv = 1'b1;
              state_d = ST_WR;
            end
          end
        end
        default: begin
          if (bus_err) begin
            ev[SB_DSTERR] = 1'b1;
            state_d       = ST_IDLE;
          end else begin
            if (done_in) ext_d = 1'b1;
            if (bus_ack) begin
              dst_adv = 1'b1;
              if ((cnt == '0) || ext_q || done_in) begin
                ev[SB_DONE] = 1'b1;
                state_d     = ST_IDLE;
              end else begin
                state_d = ST_RD1;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hi_q    <= 8'h00;
      lo_q    <= 8'h00;
      ext_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      ext_q   <= ext_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign bus_req  = busy;
  assign bus_we   = (state_q == ST_WR);
  assign word     = {hi_q, lo_q};
  assign done_out = (state_q == ST_WR) && (cnt == '0);

  // R4: channel-driven termination only inside a write cycle
  assert_done_out_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_out |-> (bus_req && bus_we));

  // R12: an unanswered cycle stays open with the same direction
  assert_cycle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err && !done_in && !chan_rst) |=> (bus_req && bus_we == $past(bus_we)));

  // R6: one stop cause per event
  assert_single_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev));

  // R10: channel reset always leaves the channel idle
  assert_rst_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !busy);

  // R1: a read that is not the last byte leads to the second read
  assert_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_adv && !bus_we && cnt != CNT_LAST && state_q == ST_RD1) |=> (bus_req && !bus_we));
endmodule

// File: rtl/pack_dma_stat.sv
module pack_dma_stat
  import pack_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic [EV_W-1:0]   ev,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] status
);
  logic [EV_W-1:0] bits_q, bits_d, clr_mask;

  assign clr_mask = wr ? wdata[EV_W-1:0] : '0;

  always_comb begin
    if (chan_rst) bits_d = '0;
    else          bits_d = (bits_q & ~clr_mask) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign status = {{(STAT_W-EV_W){1'b0}}, bits_q};

  // R9: a one written clears its bit unless a new event sets it
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !chan_rst) |=> ((status[EV_W-1:0] & $past(wdata[EV_W-1:0]) & ~$past(ev)) == '0));

  // R9: without a write, no bit is lost
  assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !chan_rst) |=> ((status[EV_W-1:0] & $past(status[EV_W-1:0])) == $past(status[EV_W-1:0])));

  // R10: channel reset empties the status
  assert_rst_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (status == '0));
endmodule

// File: rtl/pack_dma.sv
module pack_dma
  import pack_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chan_rst,
  input  logic              src_step2,
  input  logic [AW-1:0]     src_base,
  input  logic [AW-1:0]     dst_base,
  input  logic [CW-1:0]     byte_count,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] status,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [15:0]       bus_wdata,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic              done_in,
  output logic              done_out
);
  logic            load, src_adv, dst_adv;
  logic [AW-1:0]   src_ptr, dst_ptr;
  logic [CW-1:0]   cnt;
  logic [EV_W-1:0] ev;

  pack_dma_ptrs #(.AW(AW), .CW(CW)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .src_base (src_base),
    .dst_base (dst_base),
    .cnt_init (byte_count),
    .step2    (src_step2),
    .src_adv  (src_adv),
    .dst_adv  (dst_adv),
    .src_ptr  (src_ptr),
    .dst_ptr  (dst_ptr),
    .cnt      (cnt)
  );

  pack_dma_seq #(.CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .chan_rst    (chan_rst),
    .cnt_init_nz (byte_count != '0),
    .cnt         (cnt),
    .bus_ack     (bus_ack),
    .bus_err     (bus_err),
    .bus_rdata   (bus_rdata),
    .done_in     (done_in),
    .load        (load),
    .src_adv     (src_adv),
    .dst_adv     (dst_adv),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .word        (bus_wdata),
    .ev          (ev),
    .busy        (busy),
    .done_out    (done_out)
  );

  pack_dma_stat u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_rst (chan_rst),
    .ev       (ev),
    .wr       (stat_wr),
    .wdata    (stat_wdata),
    .status   (status)
  );

  assign bus_addr = bus_we ? dst_ptr : src_ptr;

  // R11: a start while busy never reloads the pointers
  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !chan_rst && !bus_ack && !bus_err && !done_in) |=> ($stable(bus_addr)));
endmodule

// File: tb/pack_dma_test.sv
`timescale 1ns/1ps
module pack_dma_test;
  logic        clk, rst_n, start, chan_rst, src_step2, stat_wr;
  logic [15:0] src_base, dst_base, byte_count;
  logic [7:0]  stat_wdata, status, bus_rdata;
  logic        busy, bus_req, bus_we, bus_ack, bus_err, done_in, done_out;
  logic [15:0] bus_addr, bus_wdata;

  int n_chk = 0;
  int n_fail = 0;

  pack_dma uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_rst(chan_rst),
    .src_step2(src_step2), .src_base(src_base), .dst_base(dst_base),
    .byte_count(byte_count), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .status(status), .busy(busy), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .done_in(done_in), .done_out(done_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA7;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_stat();
    stat_wr = 1'b1; stat_wdata = 8'hFF;
    @(negedge clk);
    stat_wr = 1'b0; stat_wdata = 8'h00;
    check("R9", "status after clear-all", {24'd0, status}, 32'd0);
  endtask

  // One transfer; err_at/done_at name the bus cycle index that gets the event
  task automatic xfer(input logic [15:0] sb, input logic [15:0] db, input int n, input logic st2,
                      input int maxw, input int err_at, input int done_at, input bit poke, input bit keep);
    int rd_i = 0, wr_j = 0, cyc = 0, wt, stp;
    bit ended = 0, pend = 0;
    logic [3:0] exp_st = 4'h1;
    logic [15:0] ea, ew;
    stp = st2 ? 2 : 1;
    wt = $urandom_range(maxw, 0);
    src_base = sb; dst_base = db; byte_count = 16'(n); src_step2 = st2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int it = 0; it < 4000; it++) begin
      bus_ack = 1'b0; bus_err = 1'b0; done_in = 1'b0; start = 1'b0;
      if (ended) begin
        check("R6", "busy after terminating response", {31'd0, busy}, 32'd0);
        break;
      end
      if (!busy) begin
        check("R4", "premature stop", 32'd0, 32'd1);
        break;
      end
      if (poke && rd_i == 1) begin
        start = 1'b1; src_base = ~sb; dst_base = ~db; byte_count = 16'(n + 7); src_step2 = ~st2;
      end
      if (bus_we) begin
        ea = db + 16'(2 * wr_j);
        ew[15:8] = mb(sb + 16'(2 * wr_j * stp));
        ew[7:0]  = (2 * wr_j + 1 < n) ? mb(sb + 16'((2 * wr_j + 1) * stp)) : 8'h00;
        check("R3", "write address", {16'd0, bus_addr}, {16'd0, ea});
        check("R1", "packed word", {16'd0, bus_wdata}, {16'd0, ew});
        check("R4", "done_out in write", {31'd0, done_out}, {31'd0, (rd_i == n)});
        if (wt > 0) wt--;
        else begin
          if (cyc == err_at) begin
            bus_err = 1'b1; exp_st = 4'h4; ended = 1;
          end else begin
            bus_ack = 1'b1;
            if (cyc == done_at) done_in = 1'b1;
            if (cyc == done_at || pend || rd_i == n) begin
              ended = 1; exp_st = 4'h1;
            end
            wr_j++;
          end
          cyc++; wt = $urandom_range(maxw, 0);
        end
      end else begin
        ea = sb + 16'(rd_i * stp);
        check("R2", "read address", {16'd0, bus_addr}, {16'd0, ea});
        check("R4", "done_out low on read", {31'd0, done_out}, 32'd0);
        check("R12", "request held", {31'd0, bus_req}, 32'd1);
        bus_rdata = mb(bus_addr);
        if (wt > 0) wt--;
        else begin
          if (cyc == err_at) begin
            bus_err = 1'b1; exp_st = 4'h2; ended = 1;
          end else if (cyc == done_at && (rd_i % 2) == 0) begin
            done_in = 1'b1; exp_st = 4'h8; ended = 1;
          end else begin
            bus_ack = 1'b1;
            if (cyc == done_at) begin
              done_in = 1'b1; pend = 1;
            end
            rd_i++;
          end
          cyc++; wt = $urandom_range(maxw, 0);
        end
      end
      @(negedge clk);
    end
    start = 1'b0; bus_ack = 1'b0; bus_err = 1'b0; done_in = 1'b0;
    case (exp_st)
      4'h1:    check("R5", "status after normal stop", {24'd0, status}, {28'd0, exp_st});
      4'h2:    check("R6", "status after read error", {24'd0, status}, {28'd0, exp_st});
      4'h4:    check("R7", "status after write error", {24'd0, status}, {28'd0, exp_st});
      default: check("R8", "status after unsync stop", {24'd0, status}, {28'd0, exp_st});
    endcase
    check("R4", "bus idle after stop", {31'd0, bus_req}, 32'd0);
    if (!keep) clear_stat();
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; start = 1'b0; chan_rst = 1'b0; src_step2 = 1'b0; stat_wr = 1'b0;
    src_base = '0; dst_base = '0; byte_count = '0; stat_wdata = '0;
    bus_rdata = '0; bus_ack = 1'b0; bus_err = 1'b0; done_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "reset status", {24'd0, status}, 32'd0);
    check("R11", "reset busy", {31'd0, busy}, 32'd0);
    check("R12", "reset request", {31'd0, bus_req}, 32'd0);
    check("R4", "reset done_out", {31'd0, done_out}, 32'd0);

    // R11: zero count start ignored
    byte_count = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11", "zero-count start busy", {31'd0, busy}, 32'd0);
    check("R11", "zero-count start status", {24'd0, status}, 32'd0);

    // Directed corner cases
    xfer(16'h1000, 16'h2000, 4, 1'b0, 0, 999, 999, 1'b0, 1'b0); // R1 basic
    xfer(16'h3001, 16'h4000, 3, 1'b1, 1, 999, 999, 1'b0, 1'b0); // R3 odd count, R2 step 2
    xfer(16'hFFFE, 16'hFFFC, 6, 1'b1, 2, 999, 999, 1'b1, 1'b0); // R11 start while busy, wrap
    xfer(16'h0100, 16'h0200, 4, 1'b0, 1, 2, 999, 1'b0, 1'b0);   // R7 error on write
    xfer(16'h0300, 16'h0400, 6, 1'b0, 0, 1, 999, 1'b0, 1'b0);   // R6 error on second read
    xfer(16'h0500, 16'h0600, 8, 1'b0, 1, 999, 3, 1'b0, 1'b0);   // R8 done on first read
    xfer(16'h0700, 16'h0800, 8, 1'b1, 0, 999, 1, 1'b0, 1'b0);   // R5 done on second read
    xfer(16'h0900, 16'h0A00, 8, 1'b0, 2, 999, 5, 1'b0, 1'b0);   // R5 done on write

    // R9: partial write-one-to-clear
    xfer(16'h0B00, 16'h0C00, 2, 1'b0, 0, 0, 999, 1'b0, 1'b1);
    stat_wr = 1'b1; stat_wdata = 8'hF1;
    @(negedge clk);
    stat_wr = 1'b0;
    check("R9", "zero-bit write keeps bit 1", {24'd0, status}, 32'h2);
    stat_wr = 1'b1; stat_wdata = 8'h02;
    @(negedge clk);
    stat_wr = 1'b0;
    check("R9", "one-bit write clears bit 1", {24'd0, status}, 32'h0);

    // R10: channel reset aborts and clears
    xfer(16'h0D00, 16'h0E00, 4, 1'b0, 0, 3, 999, 1'b0, 1'b1);
    src_base = 16'h1200; dst_base = 16'h1300; byte_count = 16'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check("R12", "unanswered read held", {16'd0, bus_addr}, 32'h1200);
    chan_rst = 1'b1;
    @(negedge clk);
    chan_rst = 1'b0;
    check("R10", "busy after channel reset", {31'd0, busy}, 32'd0);
    check("R10", "status after channel reset", {24'd0, status}, 32'd0);
    xfer(16'h1400, 16'h1500, 2, 1'b0, 0, 999, 999, 1'b0, 1'b0);

    // Random transfers
    for (int t = 0; t < 40; t++) begin
      int n, tot, mode, ea, da;
      n = $urandom_range(9, 1);
      tot = n + (n + 1) / 2;
      mode = $urandom_range(3, 0);
      ea = (mode == 1) ? $urandom_range(tot - 1, 0) : 999;
      da = (mode == 2) ? $urandom_range(tot - 1, 0) : 999;
      xfer(16'($urandom), 16'($urandom), n, 1'($urandom), $urandom_range(2, 0), ea, da,
           1'($urandom_range(1, 0)), 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule